// File: doc/BRIEF.md
# Quasi-Cyclic Serially Concatenated Parity Encoder

This block is a systematic encoder for a code whose parity comes from three chained stages. The first stage is an outer circular 1+D code over the information frame. The second is a single-parity-check mixing stage, described by an m×n grid of z×z circulant blocks. The third is a non-circular accumulator acting as the inner code. A frame holds K = N_BLK·Z information bits. The encoder emits a codeword of (N_BLK+M_BLK)·Z bits: the K information bits unchanged, then M_BLK·Z parity bits.

Bits enter one per beat on a valid/ready stream, and a start-of-frame flag marks the first beat of a frame. Each information bit passes straight to the output stream in the same cycle it is accepted. It is also written into a frame register. When the frame is complete, the encoder produces the parity bits in accumulator order, one per output handshake, and flags the final bit. Input is refused until that final bit has left. The circulant size, the block counts and the signed shift table are compile-time parameters.

Top module: `qcsc_encoder`

## Requirements
- R1: After reset, and before any frame has arrived, out_valid_o and out_last_o are low. With in_sof_i low, in_ready_o is high.
- R2: While no frame is in progress, a beat with in_valid_i high and in_sof_i low is consumed (in_ready_o high, whatever out_ready_i is) and discarded. It produces no output beat.
- R3: The first K = N_BLK·Z output beats of a codeword equal the frame's input bits in arrival order. Each bit appears in the same cycle it is accepted, and in_ready_o equals out_ready_i for these beats.
- R4: The outer code bit is o[k] = u[k] XOR u[k-1] for 0 < k < K, and wraps to o[0] = u[0] XOR u[K-1].
- R5: The mixing bit for parity row r = i·Z + l (block row i, offset l) is the XOR, over block columns j whose shift x = SHIFTS[i·N_BLK + j] is non-negative, of o[j·Z + ((l + x mod Z) mod Z)]. A column with a negative shift contributes nothing.
- R6: Parity bit p[r] = p[r-1] XOR s[r], with p[-1] = 0 at the start of every frame. The parity bits follow the systematic bits in increasing r.
- R7: out_last_o is high on the final parity beat (index K + M_BLK·Z − 1) and on no other beat.
- R8: From the cycle after the last information bit is accepted until the final parity bit is taken, in_ready_o is low.
- R9: While out_valid_o is high and out_ready_i is low, the next cycle still shows out_valid_o high with the same out_data_o. No bit is dropped or repeated.
- R10: A high in_sof_i on any beat after the first beat of a frame is treated as an ordinary data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input bit valid |
| in_ready_o | output | 1 | Input bit accepted |
| in_data_i | input | 1 | Information bit |
| in_sof_i | input | 1 | Marks the first bit of a frame |
| out_valid_o | output | 1 | Output bit valid |
| out_ready_i | input | 1 | Downstream can take a bit |
| out_data_o | output | 1 | Codeword bit |
| out_last_o | output | 1 | Final bit of the codeword |

## Verification
An all-zero frame must yield all-zero parity, and an all-ones frame must do the same, because the outer code cancels every pair of bits. Either result exposes a stuck term or an inverted accumulator seed. A single one at index 0 and a single one at index K−1 each light exactly two outer bits across the frame boundary. These two frames separate a correct wrap-around from a non-circular outer code, and they locate every shift in the table through the parity pattern that follows. Random frames run under random back-pressure, with discarded beats ahead of the start flag and with start flags inside a frame. They exercise the circulant offsets, the skipped negative-shift block and the stall path together, and each bit is compared with a codeword computed independently in the bench.

// File: rtl/qcsc_pkg.sv
package qcsc_pkg;
  typedef enum logic {
    PH_SYS = 1'b0,
    PH_PAR = 1'b1
  } phase_e;
endpackage

// File: rtl/qcsc_frame_buf.sv
module qcsc_frame_buf #(
  parameter int K = 48,
  localparam int IW = (K > 1) ? $clog2(K) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic          wr_bit_i,
  output logic [K-1:0]  outer_o
);
  logic [K-1:0] info_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      info_q <= '0;
    else if (wr_en_i) info_q[wr_idx_i] <= wr_bit_i;
  end

  // circular 1+D: bit 0 pairs with the last bit of the frame
  for (genvar k = 0; k < K; k++) begin : g_outer
    assign outer_o[k] = info_q[k] ^ info_q[(k + K - 1) % K];
  end

  AST_WR_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (int'(wr_idx_i) < K)); // R3
endmodule

// File: rtl/qcsc_spc_mix.sv
module qcsc_spc_mix #(
  parameter int Z     = 16,
  parameter int N_BLK = 3,
  parameter int M_BLK = 2,
  parameter int SHIFTS [M_BLK*N_BLK] = '{2, -1, 7, -1, 5, 0},
  localparam int K  = N_BLK * Z,
  localparam int LW = $clog2(Z),
  localparam int BW = (M_BLK > 1) ? $clog2(M_BLK) : 1
) (
  input  logic [K-1:0]  outer_i,
  input  logic [BW-1:0] blk_i,
  input  logic [LW-1:0] loc_i,
  output logic          spc_o
);
  logic [M_BLK-1:0] row_bit;

  for (genvar i = 0; i < M_BLK; i++) begin : g_row
    logic [N_BLK-1:0] term;
    for (genvar j = 0; j < N_BLK; j++) begin : g_col
      localparam int X = SHIFTS[i*N_BLK + j];
      if (X < 0) begin : g_zero
        assign term[j] = 1'b0;
      end else begin : g_on
        localparam int S = X % Z;
        logic [Z-1:0]  seg;
        logic [LW:0]   sum_w;
        logic [LW-1:0] col_w;
        assign seg   = outer_i[j*Z +: Z];
        assign sum_w = {1'b0, loc_i} + (LW+1)'(S);
        assign col_w = (sum_w >= (LW+1)'(Z)) ? LW'(sum_w - (LW+1)'(Z)) : sum_w[LW-1:0];
        assign term[j] = seg[col_w];
      end
    end
    assign row_bit[i] = ^term;
  end

  assign spc_o = row_bit[blk_i];

  always_comb begin
    AST_ROW_IN_RANGE: assert (int'(blk_i) < M_BLK && int'(loc_i) < Z); // R5
  end
endmodule

// File: rtl/qcsc_accum.sv
module qcsc_accum (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic spc_i,
  output logic par_o
);
  logic acc_q;

  assign par_o = acc_q ^ spc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= 1'b0;
    else if (clr_i) acc_q <= 1'b0;
    else if (en_i)  acc_q <= par_o;
  end
endmodule

// File: rtl/qcsc_encoder.sv
module qcsc_encoder
  import qcsc_pkg::*;
#(
  parameter int Z     = 16,
  parameter int N_BLK = 3,
  parameter int M_BLK = 2,
  parameter int SHIFTS [M_BLK*N_BLK] = '{2, -1, 7, -1, 5, 0},
  localparam int K  = N_BLK * Z,
  localparam int IW = (K > 1) ? $clog2(K) : 1,
  localparam int LW = $clog2(Z),
  localparam int BW = (M_BLK > 1) ? $clog2(M_BLK) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_valid_i,
  output logic in_ready_o,
  input  logic in_data_i,
  input  logic in_sof_i,
  output logic out_valid_o,
  input  logic out_ready_i,
  output logic out_data_o,
  output logic out_last_o
);
  phase_e        phase_q;
  logic [IW-1:0] sys_cnt_q;
  logic [LW-1:0] loc_q;
  logic [BW-1:0] blk_q;

  logic          in_sys, head_drop, sys_fire, par_fire, last_par;
  logic          spc_w, par_w;
  logic [K-1:0]  outer_w;

  assign in_sys    = (phase_q == PH_SYS);
  // beats before a start flag are swallowed
  assign head_drop = in_sys && (sys_cnt_q == '0) && !in_sof_i;
  assign sys_fire  = in_sys && in_valid_i && out_ready_i && !head_drop;
  assign par_fire  = !in_sys && out_ready_i;
  assign last_par  = (blk_q == BW'(M_BLK-1)) && (loc_q == LW'(Z-1));

  assign in_ready_o  = in_sys && (out_ready_i || head_drop);
  assign out_valid_o = in_sys ? (in_valid_i && !head_drop) : 1'b1;
  assign out_data_o  = in_sys ? in_data_i : par_w;
  assign out_last_o  = !in_sys && last_par;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_SYS;
      sys_cnt_q <= '0;
      loc_q     <= '0;
      blk_q     <= '0;
    end else begin
      if (sys_fire) begin
        if (sys_cnt_q == IW'(K-1)) begin
          sys_cnt_q <= '0;
          phase_q   <= PH_PAR;
        end else begin
          sys_cnt_q <= sys_cnt_q + 1'b1;
        end
      end
      if (par_fire) begin
        if (loc_q == LW'(Z-1)) begin
          loc_q <= '0;
          if (last_par) begin
            blk_q   <= '0;
            phase_q <= PH_SYS;
          end else begin
            blk_q <= blk_q + 1'b1;
          end
        end else begin
          loc_q <= loc_q + 1'b1;
        end
      end
    end
  end

  qcsc_frame_buf #(.K(K)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (sys_fire),
    .wr_idx_i (sys_cnt_q),
    .wr_bit_i (in_data_i),
    .outer_o  (outer_w)
  );

  qcsc_spc_mix #(.Z(Z), .N_BLK(N_BLK), .M_BLK(M_BLK), .SHIFTS(SHIFTS)) u_mix (
    .outer_i (outer_w),
    .blk_i   (blk_q),
    .loc_i   (loc_q),
    .spc_o   (spc_w)
  );

  qcsc_accum u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (par_fire && last_par),
    .en_i   (par_fire),
    .spc_i  (spc_w),
    .par_o  (par_w)
  );

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_sys && !out_ready_i) |=> (out_valid_o && $stable(out_data_o))); // R9
  AST_SYS_TO_PAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_fire && sys_cnt_q == IW'(K-1)) |=> (out_valid_o && !in_ready_o)); // R8
  AST_LAST_REARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_last_o && out_ready_i) |=> (in_sys && sys_cnt_q == '0)); // R7
  AST_PAR_FROM_ROW0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_q == PH_PAR) |-> (loc_q == '0 && blk_q == '0)); // R6
endmodule

// File: tb/qcsc_encoder_tb_top.sv
module qcsc_encoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Z  = 16;
  localparam int NB = 3;
  localparam int MB = 2;
  localparam int K  = NB * Z;
  localparam int NW = (NB + MB) * Z;
  localparam int SH [MB*NB] = '{2, -1, 7, -1, 5, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_data = 1'b0, in_sof = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid, out_data, out_last;

  int n_chk = 0;
  int n_bad = 0;
  bit u [K];
  bit exp_bits [NW];

  always #(CLK_PERIOD/2) clk = ~clk;

  qcsc_encoder #(.Z(Z), .N_BLK(NB), .M_BLK(MB), .SHIFTS(SH)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .in_data_i   (in_data),
    .in_sof_i    (in_sof),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .out_data_o  (out_data),
    .out_last_o  (out_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic build_expected();
    bit o [K];
    bit acc;
    for (int k = 0; k < K; k++) o[k] = u[k] ^ u[(k + K - 1) % K];
    for (int k = 0; k < K; k++) exp_bits[k] = u[k];
    acc = 1'b0;
    for (int i = 0; i < MB; i++) begin
      for (int l = 0; l < Z; l++) begin
        bit s;
        s = 1'b0;
        for (int j = 0; j < NB; j++) begin
          int x;
          x = SH[i*NB + j];
          if (x >= 0) s ^= o[j*Z + ((l + x % Z) % Z)];
        end
        acc ^= s;
        exp_bits[K + i*Z + l] = acc;
      end
    end
  endtask

  task automatic run_frame(input int junk, input int mid_sof_at, input int stall_pct,
                           input string tag);
    int  in_idx, junk_left, out_idx, cyc;
    bit  stalled_prev, prev_d, is_junk;
    build_expected();
    in_idx = 0; junk_left = junk; out_idx = 0; cyc = 0;
    stalled_prev = 1'b0; prev_d = 1'b0;
    while (out_idx < NW) begin
      @(negedge clk);
      cyc++;
      if (cyc > 4000) begin
        chk(1'b0, "WATCHDOG", out_idx, NW);
        break;
      end
      is_junk = (junk_left > 0);
      if (is_junk) begin
        in_valid = 1'b1; in_sof = 1'b0; in_data = 1'($urandom % 2);
      end else if (in_idx < K) begin
        in_valid = 1'b1; in_data = u[in_idx];
        in_sof = (in_idx == 0) || (in_idx == mid_sof_at);
      end else begin
        in_valid = 1'($urandom % 2); in_data = 1'b1; in_sof = 1'b1;
      end
      out_ready = (int'($urandom % 100) >= stall_pct);
      #1;
      if (stalled_prev)
        chk(out_valid && out_data == prev_d, "R9", int'(out_data), int'(prev_d));
      if (is_junk) begin
        chk(!out_valid && in_ready, "R2", int'({out_valid, in_ready}), 1);
        junk_left--;
      end else if (in_idx >= K) begin
        chk(!in_ready, "R8", int'(in_ready), 0);
      end
      if (out_valid && out_ready) begin
        chk(out_data == exp_bits[out_idx], (out_idx < K) ? "R3" : tag,
            int'(out_data), int'(exp_bits[out_idx]));
        chk(out_last == (out_idx == NW-1), "R7", int'(out_last), int'(out_idx == NW-1));
        out_idx++;
      end
      stalled_prev = out_valid && !out_ready;
      prev_d = out_data;
      if (!is_junk && in_idx < K && in_valid && in_ready) in_idx++;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; out_ready = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!out_valid && !out_last, "R1", int'({out_valid, out_last}), 0);
    chk(in_ready, "R1", int'(in_ready), 1);

    // directed: zeros, wrap singles, all ones
    for (int k = 0; k < K; k++) u[k] = 1'b0;
    run_frame(0, -1, 0, "R6");
    u[0] = 1'b1;
    run_frame(0, -1, 0, "R4");
    u[0] = 1'b0; u[K-1] = 1'b1;
    run_frame(0, -1, 20, "R4");
    for (int k = 0; k < K; k++) u[k] = 1'b1;
    run_frame(0, -1, 0, "R4");

    // leading discarded beats, then a start flag inside a frame
    for (int k = 0; k < K; k++) u[k] = 1'($urandom % 2);
    run_frame(3, -1, 0, "R5");
    for (int k = 0; k < K; k++) u[k] = 1'($urandom % 2);
    run_frame(0, 20, 25, "R10");

    // random frames under back-pressure
    for (int f = 0; f < 12; f++) begin
      for (int k = 0; k < K; k++) u[k] = 1'($urandom % 2);
      run_frame(int'($urandom % 3), -1, 30, "R5");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule